// File: doc/BRIEF.md
# Hardware Performance Counter Register Bank

This block holds a processor's free-running performance counters and the control registers that govern them. There is a 64-bit cycle counter and a 64-bit retired-instruction counter. A parameter sets how many 64-bit event counters follow them, from 0 to 29. Each counter has a 16-bit event-select register. One inhibit register can stop any counter. Software reaches all of this through a single-cycle control-register port: a read returns data in the same cycle, and a write lands at the next clock edge.

Every cycle the block takes a 16-bit vector of event pulses. Bit 1 of that vector is the instruction-retire pulse. Each 64-bit counter is seen as two 32-bit words at separate low and high addresses. A matching range of user-level addresses gives read-only copies of the counters. Within that range, counter slot 1 returns the two halves of an external 64-bit time value. Any access to an address the block does not decode raises an illegal-access flag, and so does any write to the read-only range.

Top module: `perf_ctr_bank`

## Requirements
- R1: After reset the inhibit register (0x320) reads with every implemented counter's bit set (bits 0, 2 and 3 up to 2+N, where N is the event-counter count), and all counters and selectors read 0.
- R2: A write to 0x320 stores only the bits of implemented counters; bit 1 and the bits of absent counters always read 0.
- R3: With inhibit bit 0 clear, the cycle counter (slot 0) grows by exactly one per clock; with it set, the counter holds.
- R4: With inhibit bit 2 clear, the retired counter (slot 2) grows by one in each cycle where event bit 1 is high; with it set, it holds.
- R5: Event counter k (slot k, 3 to 2+N) grows by one in a cycle when its selector ANDed with the event vector is nonzero, at most once per cycle, and only while inhibit bit k is clear.
- R6: Selectors sit at 0x323 to 0x33F (slot = address bits 4:0). They keep bits 15:0 and read bits 31:16 as 0. Selectors of absent counters read 0 and ignore writes.
- R7: Slot k's low word is at 0xB00+k and its high word at 0xB80+k. Writing one word leaves the other word unchanged.
- R8: When the low word increments from 0xFFFFFFFF it becomes 0, and the high word increments at the same clock edge.
- R9: A write to either word of a counter in the same cycle as that counter's increment stores the written value, and the increment is dropped.
- R10: Reads at 0xC00+k and 0xC80+k return the same words as 0xB00+k and 0xB80+k. Slot 1 there returns time bits 31:0 and 63:32.
- R11: A write to 0xC00 to 0xC1F or 0xC80 to 0xC9F raises the illegal flag in the same cycle and changes no state.
- R12: Slots of absent counters read 0 and are legal. Slot 1 in the 0xB range, 0x321, 0x322 and addresses outside the decoded ranges raise the illegal flag and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_en | input | 1 | Access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | Register address |
| csr_wdata | input | 32 | Write data |
| evt_i | input | 16 | Event pulses, bit 1 = instruction retired |
| time_i | input | 64 | External time value |
| csr_rdata | output | 32 | Read data, 0 when the access is illegal |
| csr_illegal | output | 1 | Access rejected |

## Verification
A wrong counter state appears at the ports only when the counter is read. A missed or doubled increment therefore shows as an off-by-one value at the next read, which the bench takes a known number of edges after a write. A bad carry shows on the high word one edge after the low word wraps. A corrupted inhibit or selector register shows at once when it is read back. It also shows indirectly, within the next few pulses, as a counter that moves when it should hold or holds when it should move. A decode fault shows in the same cycle as a wrong illegal flag or as nonzero data from an absent slot.

// File: rtl/perf_ctr_pkg.sv
`timescale 1ns/1ps
package perf_ctr_pkg;
    localparam int ADDR_W    = 12;
    localparam int WORD_W    = 32;
    localparam int EVT_W     = 16;
    localparam int SLOT_W    = 5;
    localparam int FIRST_EVT = 3;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_INHIBIT,
        TGT_SELECT,
        TGT_COUNTER,
        TGT_SHADOW
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic              hi;
        logic [SLOT_W-1:0] slot;
    } dec_t;
endpackage

// File: rtl/perf_csr_decode.sv
`timescale 1ns/1ps
module perf_csr_decode
    import perf_ctr_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    always_comb begin
        dec.tgt  = TGT_NONE;
        dec.hi   = addr[7];
        dec.slot = addr[SLOT_W-1:0];
        if (addr == 12'h320) begin
            dec.tgt = TGT_INHIBIT;
        end else if (addr[11:5] == 7'b0011001 && addr[4:0] >= 5'(FIRST_EVT)) begin
            dec.tgt = TGT_SELECT;
        end else if (addr[11:8] == 4'hB && addr[6:5] == 2'b00 && addr[4:0] != 5'd1) begin
            dec.tgt = TGT_COUNTER;
        end else if (addr[11:8] == 4'hC && addr[6:5] == 2'b00) begin
            dec.tgt = TGT_SHADOW;
        end
    end
endmodule

// File: rtl/perf_evt_match.sv
`timescale 1ns/1ps
module perf_evt_match
    import perf_ctr_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_SEL   = 1,
    parameter int RET_BIT   = 1
) (
    input  logic [WORD_W-1:0]             inhibit,
    input  logic [NUM_SEL-1:0][EVT_W-1:0] sel,
    input  logic [EVT_W-1:0]              evt,
    output logic [NUM_SLOTS-1:0]          inc
);
    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        if (i == 0) begin : g_cycle
            assign inc[i] = !inhibit[i];
        end else if (i == 1) begin : g_time
            assign inc[i] = 1'b0;
        end else if (i == 2) begin : g_retire
            assign inc[i] = !inhibit[i] && evt[RET_BIT];
        end else begin : g_event
            assign inc[i] = !inhibit[i] && (|(sel[i-FIRST_EVT] & evt));
        end
    end
endmodule

// File: rtl/perf_ctr64.sv
`timescale 1ns/1ps
module perf_ctr64
    import perf_ctr_pkg::*;
(
    input  logic [2*WORD_W-1:0] cur,
    input  logic                inc,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [WORD_W-1:0]   wdata,
    output logic [2*WORD_W-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (wr_lo) begin
            nxt[WORD_W-1:0] = wdata;
        end else if (wr_hi) begin
            nxt[2*WORD_W-1:WORD_W] = wdata;
        end else if (inc) begin
            nxt = cur + 64'd1;
        end
    end
endmodule

// File: rtl/perf_ctr_bank.sv
`timescale 1ns/1ps
module perf_ctr_bank
    import perf_ctr_pkg::*;
#(
    parameter int NUM_EVT_CTRS = 1,
    parameter int RET_EVT_BIT  = 1
) (
    input  logic                csr_en,
    input  logic                clk,
    input  logic                rst_n,
    input  logic                csr_we,
    input  logic [ADDR_W-1:0]   csr_addr,
    input  logic [WORD_W-1:0]   csr_wdata,
    input  logic [EVT_W-1:0]    evt_i,
    input  logic [2*WORD_W-1:0] time_i,
    output logic [WORD_W-1:0]   csr_rdata,
    output logic                csr_illegal
);
    localparam int NUM_SLOTS = FIRST_EVT + NUM_EVT_CTRS;
    localparam int NUM_SEL   = (NUM_EVT_CTRS > 0) ? NUM_EVT_CTRS : 1;

    function automatic logic [WORD_W-1:0] impl_mask();
        logic [WORD_W-1:0] m;
        m    = '0;
        m[0] = 1'b1;
        m[2] = 1'b1;
        for (int i = 0; i < NUM_EVT_CTRS; i++) m[FIRST_EVT+i] = 1'b1;
        return m;
    endfunction

    localparam logic [WORD_W-1:0] INH_IMPL = impl_mask();

    typedef struct packed {
        logic [WORD_W-1:0]                 inh;
        logic [NUM_SEL-1:0][EVT_W-1:0]     sel;
        logic [NUM_SLOTS-1:0][2*WORD_W-1:0] ctr;
    } state_t;

    state_t st_d, st_q;

    dec_t                               dec;
    logic                               acc_ok;
    logic                               wr_ok;
    logic [NUM_SLOTS-1:0]               inc;
    logic [NUM_SLOTS-1:0]               wr_lo;
    logic [NUM_SLOTS-1:0]               wr_hi;
    logic [NUM_SLOTS-1:0][2*WORD_W-1:0] nxt;
    logic [WORD_W-1:0]                  rd;

    // observation points for the bound checker
    logic [WORD_W-1:0]   inh_q;
    logic [2*WORD_W-1:0] cyc_q;
    logic [2*WORD_W-1:0] ret_q;
    logic                cyc_wr;
    logic                ret_wr;

    perf_csr_decode u_dec (
        .addr (csr_addr),
        .dec  (dec)
    );

    perf_evt_match #(
        .NUM_SLOTS (NUM_SLOTS),
        .NUM_SEL   (NUM_SEL),
        .RET_BIT   (RET_EVT_BIT)
    ) u_match (
        .inhibit (st_q.inh),
        .sel     (st_q.sel),
        .evt     (evt_i),
        .inc     (inc)
    );

    always_comb begin
        acc_ok = csr_en && (dec.tgt != TGT_NONE) && !(csr_we && dec.tgt == TGT_SHADOW);
        wr_ok  = acc_ok && csr_we;
    end

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_ctr
        if (i == 1) begin : g_none
            assign wr_lo[i] = 1'b0;
            assign wr_hi[i] = 1'b0;
            assign nxt[i]   = '0;
        end else begin : g_cnt
            assign wr_lo[i] = wr_ok && dec.tgt == TGT_COUNTER && dec.slot == 5'(i) && !dec.hi;
            assign wr_hi[i] = wr_ok && dec.tgt == TGT_COUNTER && dec.slot == 5'(i) && dec.hi;
            perf_ctr64 u_ctr (
                .cur   (st_q.ctr[i]),
                .inc   (inc[i]),
                .wr_lo (wr_lo[i]),
                .wr_hi (wr_hi[i]),
                .wdata (csr_wdata),
                .nxt   (nxt[i])
            );
        end
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SLOTS; i++) st_d.ctr[i] = nxt[i];
        if (wr_ok && dec.tgt == TGT_INHIBIT) st_d.inh = csr_wdata & INH_IMPL;
        for (int i = 0; i < NUM_EVT_CTRS; i++) begin
            if (wr_ok && dec.tgt == TGT_SELECT && dec.slot == 5'(i + FIRST_EVT))
                st_d.sel[i] = csr_wdata[EVT_W-1:0];
        end

        rd = '0;
        case (dec.tgt)
            TGT_INHIBIT: rd = st_q.inh;
            TGT_SELECT: begin
                for (int i = 0; i < NUM_EVT_CTRS; i++)
                    if (dec.slot == 5'(i + FIRST_EVT)) rd = {{(WORD_W-EVT_W){1'b0}}, st_q.sel[i]};
            end
            TGT_COUNTER, TGT_SHADOW: begin
                for (int i = 0; i < NUM_SLOTS; i++)
                    if (dec.slot == 5'(i))
                        rd = dec.hi ? st_q.ctr[i][2*WORD_W-1:WORD_W] : st_q.ctr[i][WORD_W-1:0];
                if (dec.tgt == TGT_SHADOW && dec.slot == 5'd1)
                    rd = dec.hi ? time_i[2*WORD_W-1:WORD_W] : time_i[WORD_W-1:0];
            end
            default: rd = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.inh <= INH_IMPL;
        end else begin
            st_q <= st_d;
        end
    end

    assign csr_rdata   = acc_ok ? rd : '0;
    assign csr_illegal = csr_en && !acc_ok;

    assign inh_q  = st_q.inh;
    assign cyc_q  = st_q.ctr[0];
    assign ret_q  = st_q.ctr[2];
    assign cyc_wr = wr_lo[0] || wr_hi[0];
    assign ret_wr = wr_lo[2] || wr_hi[2];
endmodule

// File: rtl/perf_ctr_bank_chk.sv
`timescale 1ns/1ps
module perf_ctr_bank_chk #(
    parameter logic [31:0] INH_IMPL = 32'hD
) (
    input logic        clk,
    input logic        rst_n,
    input logic        csr_en,
    input logic        csr_we,
    input logic [11:0] csr_addr,
    input logic        csr_illegal,
    input logic [31:0] inh_q,
    input logic [63:0] cyc_q,
    input logic [63:0] ret_q,
    input logic        cyc_wr,
    input logic        ret_wr
);
    assert_reset_inhibit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> inh_q == INH_IMPL);

    assert_inhibit_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !inh_q[1] && ((inh_q & ~INH_IMPL) == 32'd0));

    assert_cycle_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!inh_q[0] && !cyc_wr) |=> cyc_q == $past(cyc_q) + 64'd1);

    assert_cycle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q[0] && !cyc_wr) |=> $stable(cyc_q));

    assert_retire_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inh_q[2] && !ret_wr) |=> $stable(ret_q));

    assert_shadow_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_en && csr_we && csr_addr[11:8] == 4'hC && csr_addr[6:5] == 2'b00) |-> csr_illegal);
endmodule

bind perf_ctr_bank perf_ctr_bank_chk #(.INH_IMPL(INH_IMPL)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_en      (csr_en),
    .csr_we      (csr_we),
    .csr_addr    (csr_addr),
    .csr_illegal (csr_illegal),
    .inh_q       (inh_q),
    .cyc_q       (cyc_q),
    .ret_q       (ret_q),
    .cyc_wr      (cyc_wr),
    .ret_wr      (ret_wr)
);

// File: tb/sim_perf_ctr_bank.sv
`timescale 1ns/1ps
module sim_perf_ctr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_en = 1'b0;
    logic        csr_we = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [31:0] csr_wdata = '0;
    logic [15:0] evt_i = '0;
    logic [63:0] time_i = 64'h0123_4567_89AB_CDEF;
    logic [31:0] csr_rdata;
    logic        csr_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    perf_ctr_bank u0 (
        .csr_en      (csr_en),
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .evt_i       (evt_i),
        .time_i      (time_i),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal)
    );

    typedef struct packed {
        logic        we;
        logic [11:0] a;
        logic [31:0] wd;
        logic [31:0] ex;
        logic        ill;
        logic [7:0]  r;
    } vec_t;

    // default build: one event counter, so implemented inhibit mask is 0xD
    localparam int NVEC = 31;
    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 12'h320, 32'h0,        32'h0000_000D, 1'b0, 8'd1},   // R1
        '{1'b0, 12'hB00, 32'h0,        32'h0,         1'b0, 8'd1},
        '{1'b0, 12'hB83, 32'h0,        32'h0,         1'b0, 8'd1},
        '{1'b0, 12'h323, 32'h0,        32'h0,         1'b0, 8'd1},
        '{1'b1, 12'h323, 32'hFFFF_A5A5, 32'h0,        1'b0, 8'd6},   // R6
        '{1'b0, 12'h323, 32'h0,        32'h0000_A5A5, 1'b0, 8'd6},
        '{1'b1, 12'h324, 32'h1234,     32'h0,         1'b0, 8'd6},
        '{1'b0, 12'h324, 32'h0,        32'h0,         1'b0, 8'd6},
        '{1'b1, 12'h320, 32'hFFFF_FFFF, 32'h0,        1'b0, 8'd2},   // R2
        '{1'b0, 12'h320, 32'h0,        32'h0000_000D, 1'b0, 8'd2},
        '{1'b1, 12'hB00, 32'h1111_1111, 32'h0,        1'b0, 8'd7},   // R7
        '{1'b0, 12'hB00, 32'h0,        32'h1111_1111, 1'b0, 8'd7},
        '{1'b0, 12'hB80, 32'h0,        32'h0,         1'b0, 8'd7},
        '{1'b1, 12'hB80, 32'h22,       32'h0,         1'b0, 8'd7},
        '{1'b0, 12'hB80, 32'h0,        32'h22,        1'b0, 8'd7},
        '{1'b0, 12'hB00, 32'h0,        32'h1111_1111, 1'b0, 8'd7},
        '{1'b0, 12'hC00, 32'h0,        32'h1111_1111, 1'b0, 8'd10},  // R10
        '{1'b0, 12'hC80, 32'h0,        32'h22,        1'b0, 8'd10},
        '{1'b0, 12'hC01, 32'h0,        32'h89AB_CDEF, 1'b0, 8'd10},
        '{1'b0, 12'hC81, 32'h0,        32'h0123_4567, 1'b0, 8'd10},
        '{1'b1, 12'hC00, 32'h5,        32'h0,         1'b1, 8'd11},  // R11
        '{1'b0, 12'hC00, 32'h0,        32'h1111_1111, 1'b0, 8'd11},
        '{1'b1, 12'hC83, 32'h5,        32'h0,         1'b1, 8'd11},
        '{1'b0, 12'hB83, 32'h0,        32'h0,         1'b0, 8'd11},
        '{1'b0, 12'hB01, 32'h0,        32'h0,         1'b1, 8'd12},  // R12
        '{1'b0, 12'h321, 32'h0,        32'h0,         1'b1, 8'd12},
        '{1'b0, 12'hB04, 32'h0,        32'h0,         1'b0, 8'd12},
        '{1'b0, 12'hC1F, 32'h0,        32'h0,         1'b0, 8'd12},
        '{1'b1, 12'hB1F, 32'h7,        32'h0,         1'b0, 8'd12},
        '{1'b0, 12'hB1F, 32'h0,        32'h0,         1'b0, 8'd12},
        '{1'b0, 12'h7B0, 32'h0,        32'h0,         1'b1, 8'd12}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // starts before a rising edge, ends just after the following falling edge
    task automatic do_write(input logic [11:0] a, input logic [31:0] d, output logic ill);
        csr_en = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        #1 ill = csr_illegal;
        @(posedge clk);
        @(negedge clk);
        csr_en = 1'b0; csr_we = 1'b0;
    endtask

    // combinational read inside the low phase, no clock edge consumed
    task automatic do_read(input logic [11:0] a, output logic [31:0] d, output logic ill);
        csr_en = 1'b1; csr_we = 1'b0; csr_addr = a;
        #1 d = csr_rdata; ill = csr_illegal;
        csr_en = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        logic        il;
        do_read(a, d, il);
        chk(tag, d, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic il;
        do_write(a, d, il);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        il;
        logic [15:0] pat [7];
        pat = '{16'h0001, 16'h0002, 16'h8001, 16'h0000, 16'h0100, 16'h4000, 16'h0020};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i].we) begin
                do_write(TBL[i].a, TBL[i].wd, il);
                chk($sformatf("R%0d illegal %h", TBL[i].r, TBL[i].a), {31'd0, il}, {31'd0, TBL[i].ill});
            end else begin
                do_read(TBL[i].a, d, il);
                chk($sformatf("R%0d illegal %h", TBL[i].r, TBL[i].a), {31'd0, il}, {31'd0, TBL[i].ill});
                chk($sformatf("R%0d data %h", TBL[i].r, TBL[i].a), d, TBL[i].ex);
            end
        end

        // R3 and R9: run the cycle counter, write lands instead of the increment
        wr(12'h320, 32'h0000_000C);
        wr(12'hB00, 32'd100);
        rd_chk(12'hB00, 32'd100, "R9 cycle write over increment");
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd_chk(12'hB00, 32'd105, "R3 cycle count");

        // R8: carry into the high word
        wr(12'hB80, 32'd7);
        wr(12'hB00, 32'hFFFF_FFFE);
        rd_chk(12'hB00, 32'hFFFF_FFFE, "R7 low write");
        rd_chk(12'hB80, 32'd7, "R7 high kept");
        repeat (2) @(posedge clk);
        @(negedge clk);
        rd_chk(12'hB00, 32'h0, "R8 low wrap");
        rd_chk(12'hB80, 32'd8, "R8 high carry");

        // R3 hold once inhibited
        wr(12'h320, 32'h0000_0009);
        do_read(12'hB00, d, il);
        repeat (4) @(posedge clk);
        @(negedge clk);
        rd_chk(12'hB00, d, "R3 cycle held");

        // R4: retired counter follows event bit 1
        wr(12'hB02, 32'd0);
        for (int k = 0; k < 6; k++) begin
            evt_i = (k % 2 == 1) ? 16'h0002 : 16'h0000;
            @(negedge clk);
        end
        evt_i = '0;
        rd_chk(12'hB02, 32'd3, "R4 retire count");
        rd_chk(12'hC02, 32'd3, "R10 retire shadow");
        wr(12'h320, 32'h0000_000D);
        evt_i = 16'h0002;
        repeat (3) @(negedge clk);
        evt_i = '0;
        rd_chk(12'hB02, 32'd3, "R4 retire inhibited");

        // R5: event counter 3 with selector 0xA5A5
        wr(12'h320, 32'h0000_0005);
        wr(12'hB03, 32'd0);
        for (int k = 0; k < 7; k++) begin
            evt_i = pat[k];
            @(negedge clk);
        end
        evt_i = '0;
        rd_chk(12'hB03, 32'd4, "R5 event count");
        rd_chk(12'hC03, 32'd4, "R10 event shadow");
        rd_chk(12'hB83, 32'd0, "R5 event high word");

        // R9: write beats a matching event
        evt_i = 16'h0001;
        wr(12'hB03, 32'd50);
        evt_i = '0;
        rd_chk(12'hB03, 32'd50, "R9 event write over increment");

        // R5: inhibited event counter holds
        wr(12'h320, 32'h0000_000D);
        evt_i = 16'h0001;
        repeat (2) @(negedge clk);
        evt_i = '0;
        rd_chk(12'hB03, 32'd50, "R5 event inhibited");

        // R1: reset in the middle of a run
        rst_n = 1'b0;
        @(negedge clk);
        rd_chk(12'h320, 32'h0000_000D, "R1 inhibit after reset");
        rd_chk(12'hB00, 32'h0, "R1 cycle after reset");
        rd_chk(12'hB03, 32'h0, "R1 event after reset");
        rd_chk(12'h323, 32'h0, "R1 selector after reset");
        rst_n = 1'b1;
        @(negedge clk);
        rd_chk(12'h320, 32'h0000_000D, "R1 inhibit after release");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule